// File: doc/BRIEF.md
# Floating-Point Status and Exception Unit

This block keeps the control and status word that accompanies a floating-point datapath. The word holds a rounding selector, a denormal-handling bit, five sticky exception flags, five trap enables and five per-operation cause bits. Software loads the word through a write port. Every bit that is not implemented is dropped on the way in. The word is decoded without delay into a round-toward-zero select and a flush-to-zero select, which go to the arithmetic units.

When the datapath finishes an operation, it pulses a completion strobe and presents five raw exception indications. The unit replaces the cause bits with these indications and ORs them into the sticky flags. If any fresh cause matches an enabled trap, it raises a trap request for one cycle, with a fixed vector code. Some operations only approximate their result. For those, the datapath also raises an approximate-result input, and the unit then reports inexact whenever no other exception came with the result.

All pins are plain control and status signals with no back-pressure. A completion strobe is taken in the cycle it is high. If a software write lands in the same cycle, the write wins and the completion is dropped.

Top module: `fpstat_unit`

## Requirements
- R1: After reset the status word reads 0, and trap_req and trap_code are 0.
- R2: A write stores wr_data[17:0] and forces bits 31:18 to zero. The layout is: [1:0] rounding selector, [2] denormal mode, [7:3] sticky flags, [12:8] trap enables, [17:13] causes. Inside each five-bit field, bit 0 is invalid, bit 1 is divide-by-zero, bit 2 is overflow, bit 3 is underflow and bit 4 is inexact.
- R3: round_zero is 1 exactly when the rounding selector is 2'b01. The other three codes give 0, which means round to nearest even.
- R4: flush_zero equals the denormal-mode bit.
- R5: On a completion, the cause field becomes exactly the five exception inputs, so causes from earlier operations are cleared. The selector, denormal and enable fields are left unchanged.
- R6: On a completion, the sticky flags become the old flags ORed with the new cause. A completion never clears a flag.
- R7: On a completion with op_approx high and all five exception inputs low, the cause is inexact only (5'b10000). When op_approx is high and some exception input is high, the inputs are recorded unchanged.
- R8: trap_req is high in the cycle after a completion whose new cause ANDed with the enables is nonzero, and low otherwise. trap_code is 12'h120 while trap_req is high and 0 while it is low.
- R9: When wr_en and op_done are high in the same cycle, the word takes the masked write value, and the completion causes neither a field change nor a trap.
- R10: While op_done and wr_en are both low, the exception inputs and op_approx have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software load of the status word |
| wr_data | input | 32 | Value to load |
| op_done | input | 1 | Operation-complete strobe |
| op_approx | input | 1 | Completing operation gives an approximate result |
| exc_in | input | 5 | Raw exceptions: [0] invalid, [1] div-by-zero, [2] overflow, [3] underflow, [4] inexact |
| round_zero | output | 1 | Datapath rounds toward zero |
| flush_zero | output | 1 | Datapath flushes denormals to zero |
| stat_value | output | 32 | Current status word |
| trap_req | output | 1 | Single-cycle trap request |
| trap_code | output | 12 | Trap vector code while requesting |

## Verification
A write or a completion that is applied before a rising edge changes stat_value right after that edge. round_zero and flush_zero follow the new word with no further delay. trap_req and trap_code are registered, so they become valid after the same edge as the completion and clear after the next one. The bench drives inputs on falling edges and samples all outputs on the following falling edge, which lies after exactly one rising edge. After each completion it samples once more to confirm that the trap drops. The sweep covers all 32 exception patterns, each with and without op_approx, under varied enable and flag values. The expected word and the expected trap are computed arithmetically from the fields.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int EXC_N   = 5;
  localparam int RM_W    = 2;
  localparam int USED_W  = RM_W + 1 + 3 * EXC_N;
  localparam int EX_INV  = 0;
  localparam int EX_DIV  = 1;
  localparam int EX_OVF  = 2;
  localparam int EX_UNF  = 3;
  localparam int EX_INX  = 4;
  localparam logic [RM_W-1:0] RM_TOZERO = 2'b01;

  typedef logic [EXC_N-1:0] exc_t;

  typedef struct packed {
    exc_t             cause;
    exc_t             enable;
    exc_t             flags;
    logic             denorm;
    logic [RM_W-1:0]  rmode;
  } stat_t;
endpackage

// File: rtl/fpstat_cause.sv
module fpstat_cause
  import fpstat_pkg::*;
(
  input  logic  op_approx,
  input  exc_t  exc_in,
  output exc_t  cause
);
  logic any_raw;
  assign any_raw = |exc_in;

  for (genvar b = 0; b < EXC_N; b++) begin : g_bit
    if (b == EX_INX) begin : g_inx
      assign cause[b] = exc_in[b] | (op_approx & ~any_raw);
    end else begin : g_other
      assign cause[b] = exc_in[b];
    end
  end
endmodule

// File: rtl/fpstat_reg.sv
module fpstat_reg
  import fpstat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  input  exc_t              new_cause,
  output stat_t             state,
  output logic              op_take
);
  stat_t state_q;
  stat_t state_d;
  stat_t wr_word;

  assign wr_word = stat_t'(wr_data[USED_W-1:0]);
  assign op_take = op_done & ~wr_en;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      state_d = wr_word;
    end else if (op_done) begin
      state_d.cause = new_cause;
      state_d.flags = state_q.flags | new_cause;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/fpstat_trap.sv
module fpstat_trap
  import fpstat_pkg::*;
#(
  parameter int              VEC_W    = 12,
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_take,
  input  exc_t             new_cause,
  input  exc_t             enable,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_code
);
  logic hit;
  logic trap_q;

  assign hit = op_take & (|(new_cause & enable));

  always_ff @(posedge clk) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= hit;
  end

  assign trap_req  = trap_q;
  assign trap_code = trap_q ? TRAP_VEC : '0;
endmodule

// File: rtl/fpstat_decode.sv
module fpstat_decode
  import fpstat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  stat_t             state,
  output logic              round_zero,
  output logic              flush_zero,
  output logic [DATA_W-1:0] stat_value
);
  localparam int PAD_W = DATA_W - USED_W;

  assign round_zero = (state.rmode == RM_TOZERO);
  assign flush_zero = state.denorm;

  if (PAD_W > 0) begin : g_pad
    assign stat_value = {{PAD_W{1'b0}}, state};
  end else begin : g_nopad
    assign stat_value = state[DATA_W-1:0];
  end
endmodule

// File: rtl/fpstat_unit.sv
module fpstat_unit
  import fpstat_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter int               VEC_W    = 12,
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  input  logic              op_approx,
  input  logic [EXC_N-1:0]  exc_in,
  output logic              round_zero,
  output logic              flush_zero,
  output logic [DATA_W-1:0] stat_value,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_code
);
  exc_t  new_cause;
  stat_t state;
  logic  op_take;

  fpstat_cause u_cause (
    .op_approx (op_approx),
    .exc_in    (exc_in),
    .cause     (new_cause)
  );

  fpstat_reg #(.DATA_W(DATA_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .op_done   (op_done),
    .new_cause (new_cause),
    .state     (state),
    .op_take   (op_take)
  );

  fpstat_trap #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_take   (op_take),
    .new_cause (new_cause),
    .enable    (state.enable),
    .trap_req  (trap_req),
    .trap_code (trap_code)
  );

  fpstat_decode #(.DATA_W(DATA_W)) u_dec (
    .state      (state),
    .round_zero (round_zero),
    .flush_zero (flush_zero),
    .stat_value (stat_value)
  );
endmodule

// File: rtl/fpstat_unit_chk.sv
module fpstat_unit_chk #(
  parameter int               DATA_W   = 32,
  parameter int               VEC_W    = 12,
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              op_done,
  input logic [4:0]        exc_in,
  input logic              round_zero,
  input logic              flush_zero,
  input logic [DATA_W-1:0] stat_value,
  input logic              trap_req,
  input logic [VEC_W-1:0]  trap_code
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(18'h3FFFF);

  assert_trap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(op_done) && !$past(wr_en)));

  assert_trap_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_code == (trap_req ? TRAP_VEC : '0));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stat_value == ($past(wr_data) & KEEP)) && !trap_req);

  assert_sticky_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !wr_en) |=> ((stat_value[7:3] & $past(stat_value[7:3])) == $past(stat_value[7:3])));

  assert_cause_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !wr_en && (exc_in != 5'd0)) |=> (stat_value[17:13] == $past(exc_in)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done && !wr_en) |=> $stable(stat_value));

  assert_round_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    round_zero == (stat_value[1:0] == 2'b01));

  assert_flush_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_zero == stat_value[2]);
endmodule

bind fpstat_unit fpstat_unit_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .op_done    (op_done),
  .exc_in     (exc_in),
  .round_zero (round_zero),
  .flush_zero (flush_zero),
  .stat_value (stat_value),
  .trap_req   (trap_req),
  .trap_code  (trap_code)
);

// File: tb/test_fpstat_unit.sv
module test_fpstat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic        op_approx = 1'b0;
  logic [4:0]  exc_in = '0;
  logic        round_zero, flush_zero, trap_req;
  logic [31:0] stat_value;
  logic [11:0] trap_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fpstat_unit i_fpstat_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_approx(op_approx), .exc_in(exc_in),
    .round_zero(round_zero), .flush_zero(flush_zero), .stat_value(stat_value),
    .trap_req(trap_req), .trap_code(trap_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [4:0] c, input logic [4:0] e,
                                       input logic [4:0] f, input logic d, input logic [1:0] r);
    return {14'd0, c, e, f, d, r};
  endfunction

  task automatic do_write(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_op(input logic [4:0] e, input logic ap);
    @(negedge clk);
    op_done = 1'b1; exc_in = e; op_approx = ap;
    @(negedge clk);
    op_done = 1'b0; exc_in = '0; op_approx = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 value", stat_value, 32'd0);
    chk("R1 trap", {31'd0, trap_req}, 32'd0);
    chk("R1 code", {20'd0, trap_code}, 32'd0);

    // R2 masking of unused bits
    do_write(32'hFFFF_FFFF);
    chk("R2 mask all-ones", stat_value, 32'h0003_FFFF);
    do_write(32'hA5C3_0F96);
    chk("R2 mask pattern", stat_value, 32'hA5C3_0F96 & 32'h0003_FFFF);

    // R3 R4 selector decode, all codes with both denorm values
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < 2; d++) begin
        do_write(pack(5'd0, 5'd0, 5'd0, d[0], r[1:0]));
        chk("R3 round_zero", {31'd0, round_zero}, {31'd0, (r == 1)});
        chk("R4 flush_zero", {31'd0, flush_zero}, {31'd0, d[0]});
      end
    end

    // R5 R6 R7 R8 sweep over exceptions, approx, enables, flags
    for (int x = 0; x < 32; x++) begin
      for (int a = 0; a < 2; a++) begin
        logic [4:0] en, fl, ca, nf;
        logic [1:0] rm;
        logic       dn, tr;
        en = 5'((x * 13 + a * 7 + 3) & 31);
        fl = 5'((x * 5 + a * 11) & 31);
        rm = 2'((x + a) & 3);
        dn = 1'((x >> 1) ^ a);
        do_write(pack(5'b10101, en, fl, dn, rm));
        do_op(5'(x), a[0]);
        ca = (a == 1 && x == 0) ? 5'b10000 : 5'(x);
        nf = fl | ca;
        tr = (ca & en) != 5'd0;
        chk((a == 1) ? "R7 approx word" : "R5 R6 word", stat_value,
            pack(ca, en, nf, dn, rm));
        chk("R8 trap", {31'd0, trap_req}, {31'd0, tr});
        chk("R8 code", {20'd0, trap_code}, tr ? 32'h120 : 32'd0);
        @(negedge clk);
        chk("R8 pulse drop", {31'd0, trap_req}, 32'd0);
        chk("R10 hold after op", stat_value, pack(ca, en, nf, dn, rm));
      end
    end

    // R6 accumulation across ops, and cause cleared by quiet op
    do_write(pack(5'd0, 5'd0, 5'd0, 1'b0, 2'd0));
    do_op(5'b00001, 1'b0);
    do_op(5'b01000, 1'b0);
    chk("R6 accumulate", stat_value, pack(5'b01000, 5'd0, 5'b01001, 1'b0, 2'd0));
    do_op(5'b00000, 1'b0);
    chk("R5 R6 quiet op", stat_value, pack(5'd0, 5'd0, 5'b01001, 1'b0, 2'd0));

    // R9 collision, write wins and no trap
    do_write(pack(5'd0, 5'b11111, 5'd0, 1'b0, 2'd0));
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'hFFFC_0102; op_done = 1'b1; exc_in = 5'b11111;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; op_done = 1'b0; exc_in = '0;
    chk("R9 write wins", stat_value, 32'h0000_0102);
    chk("R9 no trap", {31'd0, trap_req}, 32'd0);

    // R10 exceptions without strobe
    do_write(pack(5'b00010, 5'b11111, 5'b00100, 1'b1, 2'd1));
    @(negedge clk);
    exc_in = 5'b11111; op_approx = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 ignored value", stat_value, pack(5'b00010, 5'b11111, 5'b00100, 1'b1, 2'd1));
    chk("R10 ignored trap", {31'd0, trap_req}, 32'd0);
    exc_in = '0; op_approx = 1'b0;

    // R1 reset clears a populated word
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 re-reset", stat_value, 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule